// File: doc/BRIEF.md
# Lane Activity Monitor with Change Interrupt

The block watches 34 digital input lanes and decides, once per monitor interval, whether each lane has been active. An interval is the time between two rising edges of a slow, free-running monitor clock. A lane is judged active when at least two transitions are seen on it during the interval. At each monitor edge, the verdict for every lane is latched into a status bit. A status bit of 0 means the lane was active, and 1 means it was idle.

All logic runs on the host clock. The lanes and the monitor clock each pass through a two-flop synchronizer before they are used. When a latched verdict differs from the previous one, a pending flag is set for the status register that holds that lane. An active-low interrupt is asserted while any pending flag is set.

The host reads the read-only status registers through a simple read port. A read clears the pending flag of that register only and leaves the status bits unchanged. The interrupt therefore stays asserted until every register that recorded a change has been read.

Top module: `lane_activity_monitor`

## Requirements
- R1: At a monitor sample, a lane that had two or more transitions during the interval gets status 0 (active). A lane with zero or one transition gets status 1 (idle).
- R2: Each lane's transition count restarts at every monitor sample, so transitions counted before a sample do not carry into the next interval.
- R3: Status bits change only on a synchronized rising edge of the monitor clock. Between samples, reads return the same status even if lanes toggle.
- R4: When a sample changes any status bit, the pending flag of the register holding that lane is set. irq_no is low while any pending flag is set.
- R5: A read of address 22h+k returns lanes 4k to 4k+3 in bits [3:0], with the lowest lane in bit 0. Address 2Ah returns lanes 32 and 33 in bits [1:0]. All upper bits are 0, and any other address reads 0. rd_data_o is updated at the clock edge that captures rd_en_i and holds until the next read.
- R6: A read clears the pending flag of the addressed register only and does not change any status bit.
- R7: irq_no stays low until every register holding a changed lane has been read, and it cannot rise without a read.
- R8: If a sample changes a lane in a register in the same cycle that register is read, the pending flag stays set.
- R9: After reset, all status bits are 1, no flag is pending, irq_no is 1 and rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_i | input | 34 | Asynchronous lane data bits |
| mon_clk_i | input | 1 | Asynchronous monitor clock; each rising edge is one sample |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 8 | Registered read data |
| irq_no | output | 1 | Active-low change interrupt |

## Verification
A monitor sample that changes a lane and a host read of that lane's register can both land in the same host cycle. The two requests then compete for the same pending flag. The bench provokes this by timing the read strobe to fall in the cycle after the second synchronizer stage sees the monitor edge, which is the cycle in which the sample takes effect. The bench judges the result by checking that irq_no stays low after that read, and that it rises only after a second read of the register.

// File: rtl/lam_pkg.sv
package lam_pkg;
  // Saturating transition tally for one lane within one monitor interval
  typedef enum logic [1:0] {
    TALLY_ZERO = 2'd0,
    TALLY_ONE  = 2'd1,
    TALLY_FULL = 2'd2
  } tally_t;

  function automatic int regs_for(input int lanes, input int per_reg);
    return (lanes + per_reg - 1) / per_reg;
  endfunction
endpackage

// File: rtl/lam_sync.sv
module lam_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/lam_lane_tally.sv
module lam_lane_tally
  import lam_pkg::*;
#(
  parameter int NUM_LANES = 34
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] lane_s_i,
  input  logic                 sample_i,
  output logic [NUM_LANES-1:0] active_o
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic   prev_q;
    logic   flip;
    tally_t tally_q;

    assign flip = lane_s_i[i] ^ prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q  <= 1'b0;
        tally_q <= TALLY_ZERO;
      end else begin
        prev_q <= lane_s_i[i];
        if (sample_i) begin
          tally_q <= flip ? TALLY_ONE : TALLY_ZERO;
        end else if (flip) begin
          case (tally_q)
            TALLY_ZERO: tally_q <= TALLY_ONE;
            default:    tally_q <= TALLY_FULL;
          endcase
        end
      end
    end

    assign active_o[i] = (tally_q == TALLY_FULL);

    // R2: the tally restarts on every sample
    assert_tally_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_i |=> (tally_q != TALLY_FULL));
    // R1: the tally never leaves its legal range
    assert_tally_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tally_q != 2'd3);
  end
endmodule

// File: rtl/lam_status_regs.sv
module lam_status_regs #(
  parameter int NUM_LANES = 34,
  parameter int LPR       = 4,
  parameter int NUM_REGS  = 9,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 'h22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] active_i,
  input  logic                 sample_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [NUM_REGS-1:0]  pend_o
);
  localparam int PAD = NUM_REGS * LPR;

  logic [NUM_LANES-1:0] status_q;
  logic [NUM_LANES-1:0] diff;
  logic [PAD-1:0]       diff_pad, stat_pad;
  logic [NUM_REGS-1:0]  grp_chg, rd_sel, pend_q;
  logic [ADDR_W-1:0]    rd_off;
  logic                 rd_hit;
  logic [DATA_W-1:0]    rd_word;

  assign diff = status_q ^ ~active_i;

  if (PAD > NUM_LANES) begin : g_pad
    assign diff_pad = {{(PAD-NUM_LANES){1'b0}}, diff};
    assign stat_pad = {{(PAD-NUM_LANES){1'b0}}, status_q};
  end else begin : g_nopad
    assign diff_pad = diff;
    assign stat_pad = status_q;
  end

  assign rd_off = rd_addr_i - ADDR_W'(BASE_ADDR);
  assign rd_hit = (rd_addr_i >= ADDR_W'(BASE_ADDR)) && (rd_off < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '1;
    else if (sample_i) status_q <= ~active_i;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign grp_chg[g] = sample_i && |diff_pad[g*LPR +: LPR];
    assign rd_sel[g]  = rd_en_i && rd_hit && (rd_off == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_q[g] <= 1'b0;
      else if (grp_chg[g]) pend_q[g] <= 1'b1;
      else if (rd_sel[g])  pend_q[g] <= 1'b0;
    end

    // R8: a change in the same cycle as a read keeps the flag
    assert_change_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grp_chg[g] |=> pend_q[g]);
    // R6: a read without a concurrent change clears the flag
    assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_sel[g] && !grp_chg[g]) |=> !pend_q[g]);
  end

  always_comb begin
    rd_word = '0;
    for (int g = 0; g < NUM_REGS; g++) begin
      if (rd_hit && rd_off == ADDR_W'(g)) rd_word[LPR-1:0] = stat_pad[g*LPR +: LPR];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_word;
  end

  assign pend_o = pend_q;

  // R3: status moves only on a sample
  assert_status_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(status_q));
  // R6: reads never disturb status
  assert_read_no_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !sample_i) |=> $stable(status_q));
endmodule

// File: rtl/lane_activity_monitor.sv
module lane_activity_monitor
  import lam_pkg::*;
#(
  parameter int NUM_LANES = 34,
  parameter int LPR       = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 'h22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LANES-1:0] lane_i,
  input  logic                 mon_clk_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 irq_no
);
  localparam int NUM_REGS = regs_for(NUM_LANES, LPR);

  logic [NUM_LANES-1:0] lane_s, active;
  logic                 mon_s, mon_d, sample;
  logic [NUM_REGS-1:0]  pend;

  lam_sync #(.W(NUM_LANES)) i_lane_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lane_i), .q_o(lane_s)
  );

  lam_sync #(.W(1)) i_mon_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mon_clk_i), .q_o(mon_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mon_d <= 1'b0;
    else         mon_d <= mon_s;
  end

  assign sample = mon_s & ~mon_d;

  lam_lane_tally #(.NUM_LANES(NUM_LANES)) i_tally (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_s_i(lane_s),
    .sample_i(sample), .active_o(active)
  );

  lam_status_regs #(
    .NUM_LANES(NUM_LANES), .LPR(LPR), .NUM_REGS(NUM_REGS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .sample_i(sample),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pend_o(pend)
  );

  assign irq_no = ~|pend;

  // R4: the interrupt asserts only as a result of a sample
  assert_irq_from_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(sample));
  // R7: without a read the interrupt cannot release
  assert_irq_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !rd_en_i) |=> !irq_no);
endmodule

// File: tb/test_lane_activity_monitor.sv
`timescale 1ns/1ps
module test_lane_activity_monitor;
  localparam int NL = 34;
  // vector: {toggle count[2:0], lane mask[33:0]}
  localparam int NV = 8;
  localparam logic [36:0] VEC [NV] = '{
    {3'd2, 34'h0_0000_0001},
    {3'd2, 34'h0_0000_0001},
    {3'd0, 34'h0_0000_0000},
    {3'd3, 34'h3_0000_0001},
    {3'd1, 34'h3_FFFF_FFFF},
    {3'd2, 34'h2_AAAA_5555},
    {3'd2, 34'h2_AAAA_5555},
    {3'd5, 34'h0_0F0F_00F0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lanes = '0;
  logic          mon = 1'b0;
  logic          rd_en = 1'b0;
  logic [5:0]    rd_addr = '0;
  logic [7:0]    rd_data;
  logic          irq_n;
  int            checks = 0;
  int            failures = 0;
  logic [NL-1:0] exp_stat;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  lane_activity_monitor i_lane_activity_monitor (
    .clk_i(clk), .rst_ni(rst_n), .lane_i(lanes), .mon_clk_i(mon),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_no(irq_n)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_model(input int k);
    logic [7:0] v = '0;
    for (int b = 0; b < 4; b++) if (4*k+b < NL) v[b] = exp_stat[4*k+b];
    return v;
  endfunction

  task automatic do_read(input logic [5:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic toggle(input logic [NL-1:0] m, input int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk); lanes = lanes ^ m;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_mon();
    @(negedge clk); mon = 1'b1;
    repeat (4) @(negedge clk); mon = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; lanes = '0; mon = 1'b0; rd_en = 1'b0;
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_stat = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: reset state
    check("R9 irq_n", irq_n, 1'b1);
    check("R9 rd_data", rd_data, 8'h00);
    for (int k = 0; k < 9; k++) begin
      do_read(6'h22 + 6'(k));
      check("R9 status reg", rd_data, (k == 8) ? 8'h03 : 8'h0F);
    end
    do_read(6'h10); check("R5 unmapped low", rd_data, 8'h00);
    do_read(6'h2B); check("R5 unmapped high", rd_data, 8'h00);

    // vector table: R1 R2 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      logic [NL-1:0] m;
      int n;
      logic [NL-1:0] nxt;
      m = VEC[v][NL-1:0];
      n = int'(VEC[v][36:34]);
      toggle(m, n);
      pulse_mon();
      for (int i = 0; i < NL; i++) nxt[i] = (m[i] && n >= 2) ? 1'b0 : 1'b1;
      check("R4 irq after sample", irq_n, (nxt == exp_stat) ? 1'b1 : 1'b0);
      exp_stat = nxt;
      for (int k = 0; k < 9; k++) begin
        do_read(6'h22 + 6'(k));
        check("R1 R5 status read", rd_data, reg_model(k));
      end
      check("R7 irq released after all reads", irq_n, 1'b1);
    end

    // directed: R3, R6, R7
    do_reset();
    toggle(34'h2_0000_0020, 2);
    do_read(6'h23);
    check("R3 no update before sample", rd_data, 8'h0F);
    check("R3 no irq before sample", irq_n, 1'b1);
    pulse_mon();
    check("R4 irq two regs changed", irq_n, 1'b0);
    do_read(6'h23);
    check("R1 lane5 active", rd_data, 8'h0D);
    check("R7 irq held one reg unread", irq_n, 1'b0);
    do_read(6'h23);
    check("R6 status unchanged by read", rd_data, 8'h0D);
    check("R7 irq held after reread", irq_n, 1'b0);
    do_read(6'h2A);
    check("R5 lane33 bit1", rd_data, 8'h01);
    check("R7 irq released", irq_n, 1'b1);

    // R8: read of 23h coincides with a sample that changes lanes 4 and 5
    toggle(34'h0_0000_0010, 2);
    @(negedge clk); mon = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd_en = 1'b1; rd_addr = 6'h23;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
    repeat (3) @(negedge clk); mon = 1'b0;
    repeat (4) @(negedge clk);
    do_read(6'h2A);
    check("R8 pending kept after same-cycle read", irq_n, 1'b0);
    do_read(6'h23);
    check("R8 status after collision", rd_data, 8'h0E);
    check("R8 irq released after second read", irq_n, 1'b1);

    // R2: tally restarts; no transitions in next interval -> idle again
    pulse_mon();
    check("R2 change to idle", irq_n, 1'b0);
    do_read(6'h23);
    check("R2 lane4 idle after empty interval", rd_data, 8'h0F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule